// File: doc/BRIEF.md
# Transfer Group Interrupt Flag Controller

This block collects the events of one transfer group in a parallel digital I/O engine and turns them into a single interrupt request. Four events arrive as one-cycle pulses from the group's sequencer, and each one latches into a sticky flag:

- count expired
- handshake waited
- primary terminal count
- secondary terminal count

A fifth flag, transfer ready, is not sticky. It follows the FIFO-not-empty level directly.

Software uses a byte-wide register port. It reads the flags, removes them through two separate write-one-to-clear registers, and selects which flags may raise the interrupt. The first clear register also issues one-cycle reset strobes to the FIFO and to the DMA engine. A master control register holds the interrupt line select and an open-drain option. Writing zero to the master control register silences the interrupt, which lets a handler stop a source that keeps firing. A group status register reports a data-left summary, along with the request and stop-trigger levels.

The register port has no back-pressure. A write takes effect on the clock edge where `wr_en_i` is high. Reads are combinational from `addr_i`.

Top module: `tfc_top`

## Requirements
- R1: After reset, every sticky flag, the enable register and the master control register read 0, and `irq_o`, `fifo_reset_o` and `dma_reset_o` are low.
- R2: The flags register (address 0) reports the following bits, and bits 2 to 4 read 0:
  - bit 1 count expired, bit 5 waited, bit 6 primary terminal count, bit 7 secondary terminal count. Each is set by its event pulse and holds until cleared.
  - bit 0 transfer ready, which equals `fifo_nonempty_i`.
- R3: Writing clear register A (address 1) clears flags as follows, and leaves every other flag unchanged (count expired included):
  - bit 3 clears waited.
  - bit 4 clears primary terminal count.
  - bit 5 clears secondary terminal count.
- R4: Writing bit 0 of clear register B (address 2) clears count expired only.
- R5: When an event pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Writing clear register A with these bits produces a one-cycle high pulse in the cycle after the write edge:
  - bit 6 pulses `dma_reset_o`.
  - bit 7 pulses `fifo_reset_o`.

  Writing 0xF8 clears waited and both terminal counts and pulses both resets.
- R7: The enable register (address 3) uses the flag bit positions, and its bits 2 to 4 read 0. `irq_o` is high exactly when the line select is nonzero and some enabled flag is set.
- R8: The master control register (address 4) works as follows:
  - bits [1:0] are the line select, driven on `irq_line_o`.
  - bit 2 is the open-drain option, driven on `irq_open_drain_o`.
  - writing 0 forces `irq_o` low even with enabled flags set.
- R9: The group status register (address 5) reports the following bits, and its other bits read 0:
  - bit 0 data left, equal to `irq_o`.
  - bit 2 `req_i`.
  - bit 3 `stop_trig_i`.
- R10: No register write clears or changes transfer ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| fifo_nonempty_i | input | 1 | FIFO holds data (transfer ready level) |
| evt_expired_i | input | 1 | Count expired event pulse |
| evt_waited_i | input | 1 | Handshake waited event pulse |
| evt_ptc_i | input | 1 | Primary terminal count pulse |
| evt_stc_i | input | 1 | Secondary terminal count pulse |
| req_i | input | 1 | Request line level |
| stop_trig_i | input | 1 | Stop trigger level |
| irq_o | output | 1 | Interrupt request |
| irq_line_o | output | 2 | Selected interrupt line |
| irq_open_drain_o | output | 1 | Open-drain interrupt option |
| fifo_reset_o | output | 1 | One-cycle FIFO reset strobe |
| dma_reset_o | output | 1 | One-cycle DMA reset strobe |

## Verification
The assertions check four things on every cycle:
- Each sticky flag is set after its pulse, even against a clear, and is cleared after a clear that has no competing pulse.
- Each sticky flag holds otherwise.
- Each reset strobe follows a matching write.
- The interrupt never rises with a zero line select, and data left always equals the interrupt.

Only the bench scenarios can show the rest:
- the exact bit placement in the flags, enable and status registers;
- the split between the two clear registers;
- that transfer ready survives a write of all ones;
- that dropping the master control to zero silences an active source.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int NFLAG   = 8;

  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLR_A = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR_B = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_GSTAT = 3'd5;

  // flag bit positions (shared by flags and enable registers)
  localparam int F_RDY = 0;
  localparam int F_EXP = 1;
  localparam int F_WAI = 5;
  localparam int F_PTC = 6;
  localparam int F_STC = 7;

  localparam logic [NFLAG-1:0] STICKY_MASK = 8'b1110_0010;
  localparam logic [NFLAG-1:0] VALID_MASK  = 8'b1110_0011;

  // clear register A bit positions
  localparam int CA_WAI = 3;
  localparam int CA_PTC = 4;
  localparam int CA_STC = 5;
  localparam int CA_DMA = 6;
  localparam int CA_FIFO = 7;

  typedef struct packed {
    logic       od;
    logic [1:0] line;
  } mctl_t;
endpackage

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
  parameter int N = 8,
  parameter logic [N-1:0] STICKY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    if (STICKY[k]) begin : g_sticky
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[k]) q <= 1'b1;
        else if (clr_i[k]) q <= 1'b0;
      end
      assign flags_o[k] = q;

      // R5
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> flags_o[k]);
      // R3
      clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
      // R2
      flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i[k] && !clr_i[k]) |=> $stable(flags_o[k]));
    end else begin : g_level
      assign flags_o[k] = level_i[k];
    end
  end
endmodule

// File: rtl/tfc_regs.sv
module tfc_regs
  import tfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NFLAG-1:0]  clr_o,
  output logic [NFLAG-1:0]  ien_o,
  output mctl_t             mctl_o,
  output logic              fifo_reset_o,
  output logic              dma_reset_o
);
  logic wr_a, wr_b;
  assign wr_a = wr_en_i && (addr_i == A_CLR_A);
  assign wr_b = wr_en_i && (addr_i == A_CLR_B);

  always_comb begin
    clr_o        = '0;
    clr_o[F_WAI] = wr_a && wdata_i[CA_WAI];
    clr_o[F_PTC] = wr_a && wdata_i[CA_PTC];
    clr_o[F_STC] = wr_a && wdata_i[CA_STC];
    clr_o[F_EXP] = wr_b && wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o        <= '0;
      mctl_o       <= '0;
      fifo_reset_o <= 1'b0;
      dma_reset_o  <= 1'b0;
    end else begin
      fifo_reset_o <= wr_a && wdata_i[CA_FIFO];
      dma_reset_o  <= wr_a && wdata_i[CA_DMA];
      if (wr_en_i && addr_i == A_IEN)  ien_o  <= wdata_i & VALID_MASK;
      if (wr_en_i && addr_i == A_MCTL) mctl_o <= wdata_i[2:0];
    end
  end

  // R6
  dma_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_reset_o |-> $past(wr_a && wdata_i[CA_DMA]));
  // R6
  fifo_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_reset_o |-> $past(wr_a && wdata_i[CA_FIFO]));
endmodule

// File: rtl/tfc_irq.sv
module tfc_irq
  import tfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] ien_i,
  input  mctl_t            mctl_i,
  output logic             pending_o
);
  logic any_en;
  assign any_en    = |(flags_i & ien_i);
  assign pending_o = (mctl_i.line != 2'd0) && any_en;

  // R8
  irq_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> (mctl_i.line != 2'd0));
endmodule

// File: rtl/tfc_top.sv
module tfc_top
  import tfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fifo_nonempty_i,
  input  logic              evt_expired_i,
  input  logic              evt_waited_i,
  input  logic              evt_ptc_i,
  input  logic              evt_stc_i,
  input  logic              req_i,
  input  logic              stop_trig_i,
  output logic              irq_o,
  output logic [1:0]        irq_line_o,
  output logic              irq_open_drain_o,
  output logic              fifo_reset_o,
  output logic              dma_reset_o
);
  logic [NFLAG-1:0] set_v, clr_v, lvl_v, flags, ien;
  mctl_t            mctl;
  logic             data_left;

  always_comb begin
    set_v        = '0;
    set_v[F_EXP] = evt_expired_i;
    set_v[F_WAI] = evt_waited_i;
    set_v[F_PTC] = evt_ptc_i;
    set_v[F_STC] = evt_stc_i;
    lvl_v        = '0;
    lvl_v[F_RDY] = fifo_nonempty_i;
  end

  tfc_flag_bank #(.N(NFLAG), .STICKY(STICKY_MASK)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v),
    .level_i(lvl_v), .flags_o(flags)
  );

  tfc_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .clr_o(clr_v), .ien_o(ien), .mctl_o(mctl),
    .fifo_reset_o(fifo_reset_o), .dma_reset_o(dma_reset_o)
  );

  tfc_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .flags_i(flags), .ien_i(ien),
    .mctl_i(mctl), .pending_o(data_left)
  );

  assign irq_o            = data_left;
  assign irq_line_o       = mctl.line;
  assign irq_open_drain_o = mctl.od;

  always_comb begin
    unique case (addr_i)
      A_FLAGS: rdata_o = flags & VALID_MASK;
      A_IEN:   rdata_o = ien;
      A_MCTL:  rdata_o = {5'd0, mctl};
      A_GSTAT: rdata_o = {4'd0, stop_trig_i, req_i, 1'b0, data_left};
      default: rdata_o = '0;
    endcase
  end

  // R9
  summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == rdata_o[0] || addr_i != A_GSTAT);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && !fifo_reset_o && !dma_reset_o));
endmodule

// File: tb/test_tfc_top.sv
module test_tfc_top;
  logic clk = 0, rst_n = 0;
  logic wr = 0; logic [2:0] addr = 0; logic [7:0] wd = 0;
  logic [7:0] rd;
  logic fne = 0, e_exp = 0, e_wai = 0, e_ptc = 0, e_stc = 0, req = 0, stp = 0;
  logic irq, od, frst, drst; logic [1:0] line;

  always #5 clk = ~clk;

  tfc_top i_tfc_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rd), .fifo_nonempty_i(fne), .evt_expired_i(e_exp),
    .evt_waited_i(e_wai), .evt_ptc_i(e_ptc), .evt_stc_i(e_stc),
    .req_i(req), .stop_trig_i(stp), .irq_o(irq), .irq_line_o(line),
    .irq_open_drain_o(od), .fifo_reset_o(frst), .dma_reset_o(drst)
  );

  typedef struct packed { logic [2:0] kind; logic [7:0] val; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int tests = 0, fails = 0, cyc = 0;

  // kinds: 0 rdata, 1 irq, 2 fifo reset, 3 dma reset, 4 {od,line}
  task automatic push(input logic [2:0] k, input logic [7:0] v, input string t);
    exp_q.push_back('{kind: k, val: v});
    tag_q.push_back(t);
  endtask

  initial begin : monitor
    forever begin
      exp_t  e; string t; logic [7:0] act;
      wait (exp_q.size() > 0);
      #1;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      case (e.kind)
        3'd0: act = rd;
        3'd1: act = {7'd0, irq};
        3'd2: act = {7'd0, frst};
        3'd3: act = {7'd0, drst};
        default: act = {5'd0, od, line};
      endcase
      tests++;
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, act, e.val);
      end
    end
  end

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; #1; push(3'd0, e, t);
  endtask
  task automatic out_chk(input logic [2:0] k, input logic [7:0] e, input string t);
    @(negedge clk); #1; push(k, e, t);
  endtask
  // inputs: {stc,ptc,waited,expired}
  task automatic wr_ev(input logic w, input logic [2:0] a, input logic [7:0] d,
                       input logic [3:0] ev);
    @(negedge clk);
    wr = w; addr = a; wd = d;
    {e_stc, e_ptc, e_wai, e_exp} = ev;
    @(negedge clk);
    wr = 0; {e_stc, e_ptc, e_wai, e_exp} = 4'd0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk(3'd0, 8'h00, "R1 flags after reset");
    rd_chk(3'd3, 8'h00, "R1 enable after reset");
    rd_chk(3'd4, 8'h00, "R1 master after reset");
    out_chk(3'd1, 8'h00, "R1 irq after reset");
    out_chk(3'd2, 8'h00, "R1 fifo reset low");
    @(negedge clk); fne = 1;
    rd_chk(3'd0, 8'h01, "R2 transfer ready level");
    wr_ev(0, 3'd0, 8'h00, 4'b0001);
    rd_chk(3'd0, 8'h03, "R2 expired sticky");
    wr_ev(0, 3'd0, 8'h00, 4'b1110);
    rd_chk(3'd0, 8'hE3, "R2 waited/ptc/stc sticky");
    wr_ev(1, 3'd1, 8'h08, 4'b0000);
    rd_chk(3'd0, 8'hC3, "R3 clear waited only");
    wr_ev(1, 3'd1, 8'h30, 4'b0000);
    rd_chk(3'd0, 8'h03, "R3 clear tc, expired kept");
    wr_ev(1, 3'd1, 8'h3F, 4'b0000);
    rd_chk(3'd0, 8'h03, "R10 ready survives clear writes");
    wr_ev(1, 3'd2, 8'h01, 4'b0000);
    rd_chk(3'd0, 8'h01, "R4 clear expired");
    wr_ev(0, 3'd0, 8'h00, 4'b0010);
    wr_ev(1, 3'd2, 8'hFF, 4'b0000);
    rd_chk(3'd0, 8'h21, "R4 clear B leaves waited");
    wr_ev(1, 3'd1, 8'h08, 4'b0010);
    rd_chk(3'd0, 8'h21, "R5 set beats clear A");
    wr_ev(1, 3'd2, 8'h01, 4'b0001);
    rd_chk(3'd0, 8'h23, "R5 set beats clear B");
    wr_ev(1, 3'd1, 8'h40, 4'b0000);
    #1; push(3'd3, 8'h01, "R6 dma reset pulse");
    push(3'd2, 8'h00, "R6 no fifo reset");
    out_chk(3'd3, 8'h00, "R6 dma pulse one cycle");
    wr_ev(0, 3'd0, 8'h00, 4'b1100);
    wr_ev(1, 3'd1, 8'hF8, 4'b0000);
    #1; push(3'd3, 8'h01, "R6 F8 dma reset");
    push(3'd2, 8'h01, "R6 F8 fifo reset");
    rd_chk(3'd0, 8'h03, "R6 F8 clears waited and tcs");
    @(negedge clk); fne = 0;
    rd_chk(3'd0, 8'h02, "R2 ready follows level low");
    wr_ev(1, 3'd3, 8'hFF, 4'b0000);
    rd_chk(3'd3, 8'hE3, "R7 enable bits 2-4 read 0");
    wr_ev(1, 3'd3, 8'h02, 4'b0000);
    out_chk(3'd1, 8'h00, "R8 no irq with master 0");
    wr_ev(1, 3'd4, 8'h01, 4'b0000);
    out_chk(3'd1, 8'h01, "R7 irq on enabled expired");
    rd_chk(3'd5, 8'h01, "R9 data left set");
    wr_ev(1, 3'd4, 8'h00, 4'b0000);
    out_chk(3'd1, 8'h00, "R8 master 0 silences");
    rd_chk(3'd5, 8'h00, "R9 data left clear");
    wr_ev(1, 3'd4, 8'h07, 4'b0000);
    rd_chk(3'd4, 8'h07, "R8 master readback");
    out_chk(3'd4, 8'h07, "R8 line and open-drain pins");
    wr_ev(1, 3'd3, 8'h20, 4'b0000);
    out_chk(3'd1, 8'h00, "R7 masked expired no irq");
    wr_ev(0, 3'd0, 8'h00, 4'b0010);
    out_chk(3'd1, 8'h01, "R7 irq on enabled waited");
    @(negedge clk); req = 1; stp = 1;
    rd_chk(3'd5, 8'h0D, "R9 status req/stop/data-left");
    wr_ev(1, 3'd1, 8'h08, 4'b0000);
    wr_ev(1, 3'd3, 8'h01, 4'b0000);
    out_chk(3'd1, 8'h00, "R7 ready enabled but low");
    @(negedge clk); fne = 1;
    out_chk(3'd1, 8'h01, "R7 irq on transfer ready");
    wait (exp_q.size() == 0);
    #2;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule